// File: doc/BRIEF.md
# Audio Codec Control Register File

A 16-bit control register file for an audio codec. A host reaches it through a simple parallel port: a word address, write data, a write strobe and a read strobe. It holds the stereo master volume and mute controls, a mixer mode register and a link configuration register. It decodes these into attenuation and mute controls for the line-out, center and LFE attenuators, and into down-mix and spread mode bits for the mixer.

Address bit 0 is ignored, so each odd address reaches the even register just below it. A write of any value to address 0x00 reloads the volume and mode registers with their default values. The link configuration register keeps its value through this soft reset. A read of address 0x00 returns a fixed capability code.

Each 6-bit volume field saturates: if the top bit of the field is written as 1, all six bits are stored as 1. A mode bit chooses between one mute bit acting on both channels and two separate per-channel mutes.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After rst_ni is released, the master volume register (0x02) reads 0x8000, the mode register (0x76) reads 0x0000 and the link register (0x74) reads 0x0000. Both channel mutes are active and both attenuations are 0.
- R2: Address bit 0 is ignored. Any access to address 2k+1 has the same effect as an access to address 2k.
- R3: A read of address 0x00 returns 0x0090. Bits 4 (headphone output) and 7 (20-bit DAC) are 1. All other bits, including the enhancement field in bits 14:10, are 0.
- R4: A write of any value to address 0x00 restores master volume to 0x8000 and mode to 0x0000 in the next cycle. The link register keeps its value.
- R5: Master volume layout: bit 15 is the main mute, bits 13:8 are the left attenuation (1.5 dB per step), bit 7 is the right mute and bits 5:0 are the right attenuation. If bit 13 is written as 1, the left field is stored as 0x3F. If bit 5 is written as 1, the right field is stored as 0x3F. Reads and the att outputs reflect the stored value.
- R6: With mode bit 0 (split) clear, bit 15 mutes both channels. Bit 7 reads as 0 and has no effect on mute_r_o. A bit 7 written while split is clear is dropped.
- R7: With split set, bit 15 mutes only the left channel and bit 7 mutes only the right channel.
- R8: With mode bit 1 (follow) set, the center outputs copy the left attenuation and mute, and the LFE outputs copy the right attenuation and mute. With follow clear, the center and LFE outputs are 0.
- R9: Mode register layout: bit 0 is split, bit 1 is follow, bits 3:2 drive dmix_o and bit 4 drives spread_o. Its other bits, and master bits 14 and 6, read as 0.
- R10: A read of an unimplemented address returns 0x0000. A write to an unimplemented address changes no register.
- R11: rdata_o updates at the clock edge that samples re_i high, and holds its value while re_i is low.
- R12: The link register (0x74) stores bits 7:0, drives them on link_cfg_o and reads back 0 in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 7 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| att_l_o | output | 6 | Left line-out attenuation |
| att_r_o | output | 6 | Right line-out attenuation |
| mute_l_o | output | 1 | Left line-out mute |
| mute_r_o | output | 1 | Right line-out mute |
| ctr_att_o | output | 6 | Center attenuation |
| ctr_mute_o | output | 1 | Center mute |
| lfe_att_o | output | 6 | LFE attenuation |
| lfe_mute_o | output | 1 | LFE mute |
| dmix_o | output | 2 | Down-mix mode |
| spread_o | output | 1 | Channel spread enable |
| link_cfg_o | output | 8 | Link configuration bits |

## Verification
The hardest state to reach is a right-mute bit that was stored while split mode was on and is then hidden when split is turned off. Reaching it needs a fixed order of writes: set split, write bit 7, then clear split. After that the read value and mute_r_o must both show the bit as gone. The stimulus also writes bit 7 with split clear and then shows that enabling split does not make it reappear. The soft reset is applied while the link register holds a non-default value, which proves that it survives.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  localparam int DATA_W = 16;

  localparam logic [7:0] ADR_RESET  = 8'h00;
  localparam logic [7:0] ADR_MASTER = 8'h02;
  localparam logic [7:0] ADR_LINK   = 8'h74;
  localparam logic [7:0] ADR_MODE   = 8'h76;

  localparam logic [DATA_W-1:0] ID_CODE     = 16'h0090;
  localparam logic [DATA_W-1:0] MASTER_DFLT = 16'h8000;
  localparam logic [DATA_W-1:0] MODE_DFLT   = 16'h0000;
  localparam logic [DATA_W-1:0] MODE_MASK   = 16'h001F;
  localparam logic [DATA_W-1:0] LINK_DFLT   = 16'h0000;
  localparam logic [DATA_W-1:0] LINK_MASK   = 16'h00FF;

  typedef struct packed {
    logic       spread;
    logic [1:0] dmix;
    logic       follow;
    logic       split;
  } mode_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ID, SEL_MASTER, SEL_LINK, SEL_MODE
  } sel_e;
endpackage

// File: rtl/codec_addr_dec.sv
module codec_addr_dec
  import codec_reg_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(ADR_RESET);
  localparam logic [ADDR_W-1:0] A_MASTER = ADDR_W'(ADR_MASTER);
  localparam logic [ADDR_W-1:0] A_LINK   = ADDR_W'(ADR_LINK);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADR_MODE);

  logic [ADDR_W-1:0] word_addr;
  // bit 0 dropped: odd addresses alias down
  assign word_addr = {addr_i[ADDR_W-1:1], 1'b0};

  always_comb begin
    unique case (word_addr)
      A_ID:     sel_o = SEL_ID;
      A_MASTER: sel_o = SEL_MASTER;
      A_LINK:   sel_o = SEL_LINK;
      A_MODE:   sel_o = SEL_MODE;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/codec_mask_reg.sv
module codec_mask_reg #(
  parameter int              W        = 16,
  parameter logic [W-1:0]    RST_VAL  = '0,
  parameter logic [W-1:0]    MASK     = '1,
  parameter bit              SOFT_CLR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         soft_rst_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] INIT = RST_VAL & MASK;

  logic [W-1:0] q;
  logic         soft_hit;

  generate
    if (SOFT_CLR) begin : g_soft
      assign soft_hit = soft_rst_i;
    end else begin : g_keep
      assign soft_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= INIT;
    else if (wr_i)      q <= wdata_i & MASK;
    else if (soft_hit)  q <= INIT;
  end

  assign q_o = q;

  generate
    if (!SOFT_CLR) begin : g_keep_chk
      p_keep_soft_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_rst_i && !wr_i) |=> $stable(q_o));
    end else begin : g_clr_chk
      p_clear_soft_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_rst_i && !wr_i) |=> (q_o == INIT));
    end
  endgenerate
endmodule

// File: rtl/codec_vol_reg.sv
module codec_vol_reg
  import codec_reg_pkg::*;
#(
  parameter int VOL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              soft_rst_i,
  input  logic              split_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [VOL_W-1:0]  att_l_o,
  output logic [VOL_W-1:0]  att_r_o,
  output logic              mute_l_o,
  output logic              mute_r_o
);
  localparam int SAT = VOL_W - 1;
  localparam int PAD = 7 - VOL_W;
  localparam int LO  = 8;

  logic             mute_main, mute_right;
  logic [VOL_W-1:0] att_l, att_r;

  function automatic logic [VOL_W-1:0] sat_field(input logic [VOL_W-1:0] f);
    return f[SAT] ? '1 : f;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_main  <= MASTER_DFLT[15];
      mute_right <= 1'b0;
      att_l      <= '0;
      att_r      <= '0;
    end else if (wr_i) begin
      mute_main  <= wdata_i[15];
      mute_right <= wdata_i[7] & split_i;  // dropped unless split active
      att_l      <= sat_field(wdata_i[LO+VOL_W-1:LO]);
      att_r      <= sat_field(wdata_i[VOL_W-1:0]);
    end else if (soft_rst_i) begin
      mute_main  <= MASTER_DFLT[15];
      mute_right <= 1'b0;
      att_l      <= '0;
      att_r      <= '0;
    end
  end

  logic right_eff;
  assign right_eff = mute_right & split_i;

  assign rd_o     = {mute_main, {PAD{1'b0}}, att_l, right_eff, {PAD{1'b0}}, att_r};
  assign att_l_o  = att_l;
  assign att_r_o  = att_r;
  assign mute_l_o = mute_main;
  assign mute_r_o = split_i ? right_eff : mute_main;

  p_sat_left_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[LO+SAT]) |=> (att_l_o == '1));
  p_sat_right_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[SAT]) |=> (att_r_o == '1));
  p_soft_dflt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !wr_i) |=> (rd_o == MASTER_DFLT));
  p_rmute_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !split_i) |=> !rd_o[7]);
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int VOL_W  = 6,
  parameter int LINK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [15:0]       rdata_o,
  output logic [VOL_W-1:0]  att_l_o,
  output logic [VOL_W-1:0]  att_r_o,
  output logic              mute_l_o,
  output logic              mute_r_o,
  output logic [VOL_W-1:0]  ctr_att_o,
  output logic              ctr_mute_o,
  output logic [VOL_W-1:0]  lfe_att_o,
  output logic              lfe_mute_o,
  output logic [1:0]        dmix_o,
  output logic              spread_o,
  output logic [LINK_W-1:0] link_cfg_o
);
  localparam int MODE_W = $bits(mode_t);

  sel_e              sel;
  logic              soft_rst;
  logic [DATA_W-1:0] master_rd, mode_q, link_q, rd_mux;
  mode_t             mode;

  codec_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign soft_rst = we_i && (sel == SEL_ID);

  codec_mask_reg #(
    .W(DATA_W), .RST_VAL(MODE_DFLT), .MASK(MODE_MASK), .SOFT_CLR(1'b1)
  ) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (we_i && (sel == SEL_MODE)),
    .soft_rst_i (soft_rst),
    .wdata_i    (wdata_i),
    .q_o        (mode_q)
  );

  codec_mask_reg #(
    .W(DATA_W), .RST_VAL(LINK_DFLT), .MASK(LINK_MASK), .SOFT_CLR(1'b0)
  ) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (we_i && (sel == SEL_LINK)),
    .soft_rst_i (soft_rst),
    .wdata_i    (wdata_i),
    .q_o        (link_q)
  );

  assign mode = mode_t'(mode_q[MODE_W-1:0]);

  codec_vol_reg #(.VOL_W(VOL_W)) u_master (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (we_i && (sel == SEL_MASTER)),
    .soft_rst_i (soft_rst),
    .split_i    (mode.split),
    .wdata_i    (wdata_i),
    .rd_o       (master_rd),
    .att_l_o    (att_l_o),
    .att_r_o    (att_r_o),
    .mute_l_o   (mute_l_o),
    .mute_r_o   (mute_r_o)
  );

  // center/LFE attenuators track master only in follow mode
  assign ctr_att_o  = mode.follow ? att_l_o  : '0;
  assign ctr_mute_o = mode.follow & mute_l_o;
  assign lfe_att_o  = mode.follow ? att_r_o  : '0;
  assign lfe_mute_o = mode.follow & mute_r_o;
  assign dmix_o     = mode.dmix;
  assign spread_o   = mode.spread;
  assign link_cfg_o = link_q[LINK_W-1:0];

  always_comb begin
    unique case (sel)
      SEL_ID:     rd_mux = ID_CODE;
      SEL_MASTER: rd_mux = master_rd;
      SEL_LINK:   rd_mux = link_q;
      SEL_MODE:   rd_mux = mode_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  p_unimpl_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == SEL_NONE) |=> (rdata_o == '0));
  p_id_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == SEL_ID) |=> (rdata_o == ID_CODE));
  p_mute_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_MASTER && wdata_i[15] && !mode.split) |=> (mute_l_o && mute_r_o));
  p_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_MODE && wdata_i[1]) |=> (ctr_att_o == att_l_o && lfe_att_o == att_r_o));
endmodule

// File: tb/tb_codec_ctrl_regs.sv
module tb_codec_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] rdata;
  logic [5:0]  att_l, att_r, ctr_att, lfe_att;
  logic        mute_l, mute_r, ctr_mute, lfe_mute, spread;
  logic [1:0]  dmix;
  logic [7:0]  link_cfg;

  int checks = 0, errors = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  codec_ctrl_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata),
    .att_l_o(att_l), .att_r_o(att_r), .mute_l_o(mute_l), .mute_r_o(mute_r),
    .ctr_att_o(ctr_att), .ctr_mute_o(ctr_mute), .lfe_att_o(lfe_att),
    .lfe_mute_o(lfe_mute), .dmix_o(dmix), .spread_o(spread), .link_cfg_o(link_cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); addr = a; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= re;

  // monitor: compare registered read data one edge after the strobe
  always @(negedge clk) begin
    if (rd_seen && rst_ni) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected read", 32'(rdata), 32'hFFFFFFFF);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(rdata), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 mute_l", 32'(mute_l), 1);
    chk("R1 mute_r", 32'(mute_r), 1);
    chk("R1 att", 32'({att_l, att_r}), 0);
    rd(7'h02, 16'h8000, "R1 master dflt");
    rd(7'h76, 16'h0000, "R1 mode dflt");
    rd(7'h74, 16'h0000, "R1 link dflt");

    rd(7'h00, 16'h0090, "R3 id");
    rd(7'h01, 16'h0090, "R2 id alias");

    wr(7'h03, 16'h0A15);
    chk("R2 att_l", 32'(att_l), 32'h0A);
    chk("R2 att_r", 32'(att_r), 32'h15);
    chk("R2 mutes", 32'({mute_l, mute_r}), 0);
    rd(7'h02, 16'h0A15, "R2 master via odd");

    wr(7'h02, 16'h2101);
    chk("R5 att_l sat", 32'(att_l), 32'h3F);
    rd(7'h02, 16'h3F01, "R5 left sat read");
    wr(7'h02, 16'h0020);
    chk("R5 att_r sat", 32'(att_r), 32'h3F);
    rd(7'h02, 16'h003F, "R5 right sat read");

    wr(7'h02, 16'h8080);
    chk("R6 both muted", 32'({mute_l, mute_r}), 32'h3);
    rd(7'h02, 16'h8000, "R6 d7 reads 0");
    wr(7'h02, 16'h0080);
    chk("R6 d7 no effect", 32'(mute_r), 0);
    wr(7'h76, 16'h0001);
    rd(7'h02, 16'h0000, "R6 d7 dropped not revived");
    chk("R6 d7 dropped mute_r", 32'(mute_r), 0);

    wr(7'h02, 16'h0080);
    chk("R7 right only", 32'({mute_l, mute_r}), 32'h1);
    rd(7'h02, 16'h0080, "R7 d7 read");
    wr(7'h02, 16'h8000);
    chk("R7 left only", 32'({mute_l, mute_r}), 32'h2);
    wr(7'h02, 16'h0080);
    wr(7'h76, 16'h0000);
    rd(7'h02, 16'h0000, "R6 d7 hidden after split off");
    chk("R6 mute_r hidden", 32'(mute_r), 0);

    wr(7'h76, 16'h0002);
    wr(7'h02, 16'h0C05);
    chk("R8 ctr att", 32'(ctr_att), 32'h0C);
    chk("R8 lfe att", 32'(lfe_att), 32'h05);
    wr(7'h02, 16'h8C05);
    chk("R8 follow mutes", 32'({ctr_mute, lfe_mute}), 32'h3);
    wr(7'h76, 16'h0000);
    chk("R8 off", 32'({ctr_att, lfe_att, ctr_mute, lfe_mute}), 0);

    wr(7'h76, 16'hFFFF);
    rd(7'h76, 16'h001F, "R9 mode mask");
    chk("R9 dmix", 32'(dmix), 32'h3);
    chk("R9 spread", 32'(spread), 1);
    wr(7'h02, 16'hFFFF);
    rd(7'h02, 16'hBFBF, "R9 master reserved");

    wr(7'h10, 16'h1234);
    rd(7'h10, 16'h0000, "R10 unimpl read");
    rd(7'h7E, 16'h0000, "R10 unimpl high");
    rd(7'h02, 16'hBFBF, "R10 master untouched");
    rd(7'h76, 16'h001F, "R10 mode untouched");

    wr(7'h74, 16'hABCD);
    chk("R12 link out", 32'(link_cfg), 32'hCD);
    rd(7'h74, 16'h00CD, "R12 link read");

    wr(7'h01, 16'h5555);
    chk("R4 mutes", 32'({mute_l, mute_r}), 32'h3);
    chk("R4 att", 32'({att_l, att_r}), 0);
    chk("R4 link kept", 32'(link_cfg), 32'hCD);
    rd(7'h02, 16'h8000, "R4 master dflt");
    rd(7'h76, 16'h0000, "R4 mode dflt");
    rd(7'h74, 16'h00CD, "R4 link kept read");

    rd(7'h00, 16'h0090, "R11 latch");
    @(negedge clk); addr = 7'h02;
    repeat (3) @(negedge clk);
    chk("R11 hold", 32'(rdata), 32'h0090);
    wr(7'h02, 16'h0101);
    chk("R11 hold after write", 32'(rdata), 32'h0090);

    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule